// File: doc/BRIEF.md
# Zoom Window Pixel and Line Replicator

This block lives in a display pipeline beside the character-clock counter and the scanline counter. It decides, for every pixel slot, whether the raster position lies inside a programmable rectangular zoom window. Inside the window it produces a memory fetch address that starts from a dedicated zoom base address. It repeats each source pixel a programmable number of times horizontally. It also repeats each source line a programmable number of scanlines before stepping the line base by a row offset. Outside the window, or when zoom is switched off, the block stays silent, and the normal display path is used unchanged.

The window configuration is double-buffered. The live register inputs are copied into a shadow set on the frame-start strobe, so a window is never drawn with a mixture of old and new settings. The pixel-hold and line-hold strobes tell the memory fetch and line buffer logic when to take new source data and when to repeat the data they already have.

Top module: `zoom_replicator`

## Requirements
- R1: After reset, zoom_active, pix_advance and line_advance are 0, fetch_addr is 0, and the shadow configuration is cleared, which means zoom is disabled.
- R2: While the shadowed enable bit is 0, zoom_active, pix_advance and line_advance stay 0 and fetch_addr stays 0, whatever the counter values are.
- R3: Register inputs take effect only on the clock edge where frame_start is 1. Changes made between two frame_start pulses do not alter the outputs for the rest of the frame.
- R4: The horizontal window covers character clocks ch_cnt with start <= ch_cnt < end. Each character clock spans 8 consecutive pix_en slots.
- R5: The vertical window covers lines line_cnt with start <= line_cnt <= end, so the end line is inclusive. Each 11-bit line number is formed from its low byte register and the shared high register: bits 5:3 of zm_yhigh hold start[10:8] and bits 2:0 hold end[10:8].
- R6: When end < start on either axis (or end == start horizontally), zoom_active is never 1.
- R7: The horizontal factor is zm_xfac+1. Inside the window, the k-th pixel slot of a line (k counted from 0 at the window's left edge) fetches line_base + floor(k/(zm_xfac+1)). pix_advance is 1 on the slots where k mod (zm_xfac+1) == zm_xfac.
- R8: The vertical factor is zm_yfac+1. line_base is loaded with zm_base at frame_start. Window line w (counted from the window's top edge) uses line_base = zm_base + floor(w/(zm_yfac+1))*zm_row_step. line_advance is 1 in the line_done cycle of line w when w mod (zm_yfac+1) == zm_yfac.
- R9: fetch_addr is 17 bits wide and wraps modulo 2^17.
- R10: Outside the window, fetch_addr is 0 and pix_advance is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe at the start of a frame; loads the shadow configuration |
| line_done | input | 1 | One-cycle strobe at the end of each scanline |
| pix_en | input | 1 | Pixel slot enable |
| ch_cnt | input | 8 | Horizontal character-clock counter |
| line_cnt | input | 11 | Scanline counter |
| zm_en | input | 1 | Zoom master enable |
| zm_xfac | input | 3 | Horizontal factor minus one |
| zm_yfac | input | 3 | Vertical factor minus one |
| zm_xstart | input | 8 | Window left edge in character clocks |
| zm_xend | input | 8 | Window right edge in character clocks (exclusive) |
| zm_ystart_lo | input | 8 | Window top line, bits 7:0 |
| zm_yend_lo | input | 8 | Window bottom line, bits 7:0 |
| zm_yhigh | input | 6 | Bits 10:8 of top line (5:3) and bottom line (2:0) |
| zm_base | input | 17 | Source address of the zoomed data |
| zm_row_step | input | 10 | Address step between source lines |
| zoom_active | output | 1 | Current position lies inside the enabled window |
| fetch_addr | output | 17 | Source pixel address for the current slot |
| pix_advance | output | 1 | Last repeat of the current source pixel |
| line_advance | output | 1 | Last repeat of the current source line |

## Verification
The assertions assume that frame_start and line_done are never high in the same cycle. They also assume that pix_en is low whenever either strobe is high, and that ch_cnt and line_cnt stay inside one line and one frame between strobes. The bench drives every frame as one frame_start cycle followed by lines. Each line is made of 8 pixel slots per character clock and ends with a separate line_done cycle, so each strobe stands alone. Expected values are recomputed by arithmetic from the shadow settings that the bench itself latches at frame_start.

// File: rtl/zr_pkg.sv
package zr_pkg;
  localparam int ZR_CH_W   = 8;
  localparam int ZR_LN_W   = 11;
  localparam int ZR_ADDR_W = 17;
  localparam int ZR_FAC_W  = 3;
  localparam int ZR_ROW_W  = 10;

  typedef struct packed {
    logic                 en;
    logic [ZR_FAC_W-1:0]  xfac;
    logic [ZR_FAC_W-1:0]  yfac;
    logic [ZR_CH_W-1:0]   xs;
    logic [ZR_CH_W-1:0]   xe;
    logic [ZR_LN_W-1:0]   ys;
    logic [ZR_LN_W-1:0]   ye;
    logic [ZR_ADDR_W-1:0] base;
    logic [ZR_ROW_W-1:0]  row;
  } zr_cfg_t;
endpackage

// File: rtl/zr_window.sv
module zr_window #(
  parameter int CH_W = 8,
  parameter int LN_W = 11
) (
  input  logic [CH_W-1:0] ch,
  input  logic [LN_W-1:0] line,
  input  logic [CH_W-1:0] xs,
  input  logic [CH_W-1:0] xe,
  input  logic [LN_W-1:0] ys,
  input  logic [LN_W-1:0] ye,
  output logic            x_in,
  output logic            y_in
);
  logic x_ok, y_ok;

  // Horizontal end is exclusive, vertical end is inclusive.
  always_comb begin
    x_ok = (xe > xs);
    y_ok = (ye >= ys);
    x_in = x_ok && (ch >= xs) && (ch < xe);
    y_in = y_ok && (line >= ys) && (line <= ye);
  end
endmodule

// File: rtl/zr_hstep.sv
module zr_hstep #(
  parameter int FAC_W = 3,
  parameter int OFF_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [FAC_W-1:0] fac,
  output logic [OFF_W-1:0] h_off,
  output logic             last
);
  logic [FAC_W-1:0] rep_q, rep_n;
  logic [OFF_W-1:0] off_q, off_n;

  assign last  = (rep_q == fac);
  assign h_off = off_q;

  always_comb begin
    rep_n = rep_q;
    off_n = off_q;
    if (clear) begin
      rep_n = '0;
      off_n = '0;
    end else if (step) begin
      if (last) begin
        rep_n = '0;
        off_n = off_q + 1'b1;
      end else begin
        rep_n = rep_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_q <= '0;
      off_q <= '0;
    end else begin
      rep_q <= rep_n;
      off_q <= off_n;
    end
  end

  a_r7_rep_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rep_q <= fac);
  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear) |=> $stable(off_q));
endmodule

// File: rtl/zr_vstep.sv
module zr_vstep #(
  parameter int FAC_W  = 3,
  parameter int ADDR_W = 17,
  parameter int ROW_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              step,
  input  logic [FAC_W-1:0]  fac,
  input  logic [ROW_W-1:0]  row,
  output logic [ADDR_W-1:0] line_base,
  output logic              last
);
  logic [FAC_W-1:0]  rep_q, rep_n;
  logic [ADDR_W-1:0] lb_q, lb_n;

  assign last      = (rep_q == fac);
  assign line_base = lb_q;

  always_comb begin
    rep_n = rep_q;
    lb_n  = lb_q;
    if (load) begin
      rep_n = '0;
      lb_n  = base_in;
    end else if (step) begin
      if (last) begin
        rep_n = '0;
        lb_n  = lb_q + ADDR_W'(row);
      end else begin
        rep_n = rep_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_q <= '0;
      lb_q  <= '0;
    end else begin
      rep_q <= rep_n;
      lb_q  <= lb_n;
    end
  end

  a_r8_rep_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rep_q <= fac);
  a_r8_base_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (line_base == $past(base_in)));
endmodule

// File: rtl/zoom_replicator.sv
module zoom_replicator
  import zr_pkg::*;
#(
  parameter int CH_W   = ZR_CH_W,
  parameter int LN_W   = ZR_LN_W,
  parameter int ADDR_W = ZR_ADDR_W,
  parameter int FAC_W  = ZR_FAC_W,
  parameter int ROW_W  = ZR_ROW_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_start,
  input  logic                   line_done,
  input  logic                   pix_en,
  input  logic [CH_W-1:0]        ch_cnt,
  input  logic [LN_W-1:0]        line_cnt,
  input  logic                   zm_en,
  input  logic [FAC_W-1:0]       zm_xfac,
  input  logic [FAC_W-1:0]       zm_yfac,
  input  logic [CH_W-1:0]        zm_xstart,
  input  logic [CH_W-1:0]        zm_xend,
  input  logic [7:0]             zm_ystart_lo,
  input  logic [7:0]             zm_yend_lo,
  input  logic [2*(LN_W-8)-1:0]  zm_yhigh,
  input  logic [ADDR_W-1:0]      zm_base,
  input  logic [ROW_W-1:0]       zm_row_step,
  output logic                   zoom_active,
  output logic [ADDR_W-1:0]      fetch_addr,
  output logic                   pix_advance,
  output logic                   line_advance
);
  localparam int HI_W  = LN_W - 8;
  localparam int OFF_W = CH_W + 3;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rs_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  // Shadow configuration, loaded at frame start.
  zr_cfg_t cfg_live, cfg_q, cfg_n;
  always_comb begin
    cfg_live.en   = zm_en;
    cfg_live.xfac = zm_xfac;
    cfg_live.yfac = zm_yfac;
    cfg_live.xs   = zm_xstart;
    cfg_live.xe   = zm_xend;
    cfg_live.ys   = {zm_yhigh[2*HI_W-1:HI_W], zm_ystart_lo};
    cfg_live.ye   = {zm_yhigh[HI_W-1:0], zm_yend_lo};
    cfg_live.base = zm_base;
    cfg_live.row  = zm_row_step;
    cfg_n = frame_start ? cfg_live : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_n;
  end

  logic x_in, y_in;
  zr_window #(.CH_W(CH_W), .LN_W(LN_W)) u_win (
    .ch(ch_cnt), .line(line_cnt),
    .xs(cfg_q.xs), .xe(cfg_q.xe), .ys(cfg_q.ys), .ye(cfg_q.ye),
    .x_in(x_in), .y_in(y_in)
  );

  logic             active;
  logic [OFF_W-1:0] h_off;
  logic             h_last;
  logic [ADDR_W-1:0] line_base;
  logic             v_last;

  assign active = cfg_q.en && x_in && y_in;

  zr_hstep #(.FAC_W(FAC_W), .OFF_W(OFF_W)) u_h (
    .clk(clk), .rst_n(rst_ni),
    .clear(frame_start || line_done),
    .step(pix_en && active),
    .fac(cfg_q.xfac),
    .h_off(h_off), .last(h_last)
  );

  zr_vstep #(.FAC_W(FAC_W), .ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_v (
    .clk(clk), .rst_n(rst_ni),
    .load(frame_start), .base_in(zm_base),
    .step(line_done && cfg_q.en && y_in),
    .fac(cfg_q.yfac), .row(cfg_q.row),
    .line_base(line_base), .last(v_last)
  );

  always_comb begin
    zoom_active  = active;
    fetch_addr   = active ? (line_base + ADDR_W'(h_off)) : '0;
    pix_advance  = pix_en && active && h_last;
    line_advance = line_done && cfg_q.en && y_in && v_last;
  end

  a_r2_transparent: assert property (@(posedge clk) disable iff (!rst_ni)
    !cfg_q.en |-> (!zoom_active && !pix_advance && !line_advance && fetch_addr == '0));
  a_r3_shadow_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !frame_start |=> $stable(cfg_q));
  a_r10_outside_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    !zoom_active |-> (fetch_addr == '0 && !pix_advance));
  a_r5_line_range: assert property (@(posedge clk) disable iff (!rst_ni)
    zoom_active |-> (line_cnt >= cfg_q.ys && line_cnt <= cfg_q.ye));
  a_r6_no_empty_window: assert property (@(posedge clk) disable iff (!rst_ni)
    (cfg_q.xe <= cfg_q.xs || cfg_q.ye < cfg_q.ys) |-> !zoom_active);
endmodule

// File: tb/sim_zoom_replicator.sv
module sim_zoom_replicator;
  logic clk = 1'b0;
  logic rst_n;
  logic frame_start, line_done, pix_en;
  logic [7:0] ch_cnt;
  logic [10:0] line_cnt;
  logic zm_en;
  logic [2:0] zm_xfac, zm_yfac;
  logic [7:0] zm_xstart, zm_xend, zm_ystart_lo, zm_yend_lo;
  logic [5:0] zm_yhigh;
  logic [16:0] zm_base;
  logic [9:0] zm_row_step;
  logic zoom_active, pix_advance, line_advance;
  logic [16:0] fetch_addr;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int l_en, l_xf, l_yf, l_xs, l_xe, l_ys, l_ye, l_base, l_row;
  int m_en, m_xf, m_yf, m_xs, m_xe, m_ys, m_ye, m_base, m_row;

  always #10 clk = ~clk;

  zoom_replicator u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_done(line_done),
    .pix_en(pix_en), .ch_cnt(ch_cnt), .line_cnt(line_cnt), .zm_en(zm_en),
    .zm_xfac(zm_xfac), .zm_yfac(zm_yfac), .zm_xstart(zm_xstart), .zm_xend(zm_xend),
    .zm_ystart_lo(zm_ystart_lo), .zm_yend_lo(zm_yend_lo), .zm_yhigh(zm_yhigh),
    .zm_base(zm_base), .zm_row_step(zm_row_step), .zoom_active(zoom_active),
    .fetch_addr(fetch_addr), .pix_advance(pix_advance), .line_advance(line_advance)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int en, xf, yf, xs, xe, ys, ye, base, row);
    l_en = en; l_xf = xf; l_yf = yf; l_xs = xs; l_xe = xe;
    l_ys = ys; l_ye = ye; l_base = base; l_row = row;
    zm_en = en[0]; zm_xfac = xf[2:0]; zm_yfac = yf[2:0];
    zm_xstart = xs[7:0]; zm_xend = xe[7:0];
    zm_ystart_lo = ys[7:0]; zm_yend_lo = ye[7:0];
    zm_yhigh = {ys[10:8], ye[10:8]};
    zm_base = base[16:0]; zm_row_step = row[9:0];
  endtask

  task automatic do_frame_start();
    @(negedge clk);
    frame_start = 1'b1; pix_en = 1'b0; line_done = 1'b0;
    m_en = l_en; m_xf = l_xf; m_yf = l_yf; m_xs = l_xs; m_xe = l_xe;
    m_ys = l_ys; m_ye = l_ye; m_base = l_base; m_row = l_row;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic run_line(input int l, input string tg);
    for (int c = 0; c < 6; c++) begin
      for (int d = 0; d < 8; d++) begin
        bit inx, iny, act;
        int k, wl, ea, ep;
        @(negedge clk);
        pix_en = 1'b1; line_done = 1'b0; ch_cnt = c[7:0]; line_cnt = l[10:0];
        #5;
        inx = (c >= m_xs) && (c < m_xe);
        iny = (l >= m_ys) && (l <= m_ye);
        act = (m_en != 0) && inx && iny;
        ea = 0; ep = 0;
        if (act) begin
          k  = (c - m_xs) * 8 + d;
          wl = l - m_ys;
          ea = (m_base + (wl / (m_yf + 1)) * m_row + k / (m_xf + 1)) % 131072;
          ep = ((k % (m_xf + 1)) == m_xf) ? 1 : 0;
        end
        chk({tg, " R4 R5 zoom_active"}, int'(zoom_active), int'(act));
        chk(act ? {tg, " R7 R8 fetch_addr"} : {tg, " R10 fetch_addr"}, int'(fetch_addr), ea);
        chk(act ? {tg, " R7 pix_advance"} : {tg, " R10 pix_advance"}, int'(pix_advance), ep);
        chk({tg, " R8 line_advance idle"}, int'(line_advance), 0);
      end
    end
    begin
      bit iny;
      int el;
      @(negedge clk);
      pix_en = 1'b0; line_done = 1'b1; ch_cnt = 8'd0; line_cnt = l[10:0];
      #5;
      iny = (l >= m_ys) && (l <= m_ye);
      el = ((m_en != 0) && iny && (((l - m_ys) % (m_yf + 1)) == m_yf)) ? 1 : 0;
      chk({tg, " R8 line_advance"}, int'(line_advance), el);
      @(negedge clk);
      line_done = 1'b0;
    end
  endtask

  task automatic run_frame(input int first, input int n, input string tg);
    do_frame_start();
    for (int l = first; l < first + n; l++) run_line(l, tg);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; line_done = 1'b0; pix_en = 1'b0;
    ch_cnt = '0; line_cnt = '0;
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #5;
    chk("R1 zoom_active", int'(zoom_active), 0);
    chk("R1 fetch_addr", int'(fetch_addr), 0);
    chk("R1 pix_advance", int'(pix_advance), 0);
    chk("R1 line_advance", int'(line_advance), 0);
    // Enable inputs live but never latched: the cleared shadow keeps zoom off (R1).
    set_cfg(1, 0, 0, 0, 6, 0, 11, 5, 1);
    @(negedge clk); pix_en = 1'b1; ch_cnt = 8'd1; line_cnt = 11'd1;
    #5;
    chk("R1 shadow cleared zoom_active", int'(zoom_active), 0);
    @(negedge clk); pix_en = 1'b0;

    // Sweep every pair of factors.
    for (int xf = 0; xf < 8; xf++) begin
      for (int yf = 0; yf < 8; yf++) begin
        set_cfg(1, xf, yf, xf % 3, 5, yf % 4, 10, xf * 1000 + yf * 7, 40 + xf);
        run_frame(0, 12, "sweep");
      end
    end

    // R5: line numbers using the packed high bits.
    set_cfg(1, 1, 2, 2, 4, 1022, 1028, 500, 30);
    run_frame(1019, 13, "R5 high bits");

    // R3: changes mid-frame are held off until the next frame start.
    set_cfg(1, 2, 1, 0, 6, 0, 11, 100, 50);
    do_frame_start();
    set_cfg(0, 5, 5, 3, 4, 2, 3, 9, 9);
    for (int l = 0; l < 12; l++) run_line(l, "R3 held");

    // R2: next frame takes the disabled setting.
    run_frame(0, 12, "R2 off");

    // R6: empty windows.
    set_cfg(1, 0, 0, 4, 2, 0, 11, 10, 3);
    run_frame(0, 12, "R6 x empty");
    set_cfg(1, 0, 0, 0, 6, 8, 3, 10, 3);
    run_frame(0, 12, "R6 y empty");
    set_cfg(1, 0, 0, 3, 3, 0, 11, 10, 3);
    run_frame(0, 12, "R6 x zero width");

    // R9: address wrap.
    set_cfg(1, 0, 0, 0, 6, 0, 11, 131056, 64);
    run_frame(0, 12, "R9 wrap");

    done = 1;
    summary();
    $finish;
  end
endmodule